// File: doc/BRIEF.md
# IN Endpoint Transmit Packet Buffer

This block holds outgoing packet data for one device-side IN endpoint. A processor writes bytes one at a time through a data port and uses a small control port to commit or discard what it has written. A serial-engine port offers each committed packet with its byte length, streams its bytes on request and returns a done pulse once the packet has gone out, which hands that storage back to the processor side.

Storage is two halves of `MAXP` bytes. With `dbl_mode` low only the first half is used, so the processor waits while its packet is in flight. With `dbl_mode` high the halves ping-pong: the processor fills one half while the serial engine drains the other, and packets go out in commit order. A commit with partial data sends a short packet, a commit on an empty half sends a zero-length packet, and a commit written together with a clear flushes the half and sends a zero-length packet whose pending state stays visible until it has been transmitted. `dbl_mode` is changed only right after a `clr_all` pulse.

Top module: `inep_tx_buffer`

## Requirements
- R1: After reset `cpu_busy`, `cpu_valid` and `tx_avail` are 0 and `cpu_len` is 0.
- R2: While `cpu_busy` is 0, a `cpu_wr_en` cycle without a control write stores `cpu_wr_data` at the next byte position and raises `cpu_len` by one; the serial port later returns the bytes in write order, each shown on `tx_data` and advanced by one `tx_rd` cycle.
- R3: While `cpu_busy` is 1, data writes are ignored: the pending packet's length and contents do not change.
- R4: A control write with `ctl_commit`=1, `ctl_clear`=0 on a half holding 1 to `MAXP`-1 bytes offers that data as a short packet: `tx_avail` rises with `tx_len` equal to the byte count.
- R5: The same commit on an empty half offers a zero-length packet (`tx_avail`=1, `tx_len`=0).
- R6: A control write with `ctl_clear`=1 alone discards the processor-side half: `cpu_len` becomes 0 and `cpu_valid` 0. In double mode, if the processor-side half is already committed (both halves full), that oldest packet is discarded and `cpu_busy` drops; in single mode a clear while busy is ignored.
- R7: A control write with `ctl_commit`=1 and `ctl_clear`=1 flushes the half and offers a zero-length packet; `cpu_valid` reads 1 from the next cycle until the `tx_done` of that packet, then 0.
- R8: The write of byte number `MAXP` commits the half without any control write.
- R9: In single mode `cpu_busy` is 1 from a commit until `tx_done`, `clr_sie` or `clr_all`.
- R10: In double mode `cpu_busy` is 1 only while both halves hold committed packets; packets are offered in commit order and each `tx_done` frees the oldest.
- R11: `clr_sie` discards the packet currently offered to the serial side; `clr_all` empties both halves and returns to the reset state.
- R12: A data write in the same cycle as a control write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbl_mode | input | 1 | 1 = two-half ping-pong, 0 = single half |
| cpu_wr_en | input | 1 | Data byte write strobe |
| cpu_wr_data | input | DW | Data byte |
| ctl_wr | input | 1 | Control write strobe |
| ctl_commit | input | 1 | Commit bit of a control write |
| ctl_clear | input | 1 | Clear bit of a control write |
| clr_sie | input | 1 | Discard the packet offered to the serial side |
| clr_all | input | 1 | Empty both halves |
| cpu_busy | output | 1 | Processor-side half is committed and not writable |
| cpu_valid | output | 1 | Flush-and-send zero-length packet pending |
| cpu_len | output | LEN_W | Bytes in the processor-side half |
| tx_avail | output | 1 | A committed packet is offered |
| tx_len | output | LEN_W | Length of the offered packet |
| tx_rd | input | 1 | Advance to the next byte |
| tx_data | output | DW | Current byte of the offered packet |
| tx_done | input | 1 | Offered packet transmitted |

## Verification
Every packet length from zero to the full size is swept in both modes, so an off-by-one in the auto-commit or a zero-length commit that offers no packet shows as a wrong `tx_len` or a missing `tx_avail`. The ping-pong sequence fills both halves and then writes again, which catches a design that overwrites a queued packet or sends the halves out of order. The flush-and-send path is checked for a valid flag that drops too early, and the lone clear is checked for freeing the wrong half, which would surface as the newer packet vanishing instead of the older one.

// File: rtl/inep_pkg.sv
package inep_pkg;

    // index of one storage half
    typedef logic half_t;

    // next half in commit order; single mode always stays on half 0
    function automatic half_t next_half(input half_t h, input logic dbl);
        return dbl ? ~h : 1'b0;
    endfunction

endpackage

// File: rtl/inep_store.sv
module inep_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/inep_rdptr.sv
module inep_rdptr #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] ptr
);

    logic [W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (clr)      ptr_d = '0;
        else if (inc) ptr_d = ptr_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/inep_tx_buffer.sv
module inep_tx_buffer #(
    parameter int DW      = 8,
    parameter int MAXP    = 64,
    localparam int LEN_W  = $clog2(MAXP + 1),
    localparam int IDX_W  = $clog2(MAXP),
    localparam int AW     = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbl_mode,
    input  logic             cpu_wr_en,
    input  logic [DW-1:0]    cpu_wr_data,
    input  logic             ctl_wr,
    input  logic             ctl_commit,
    input  logic             ctl_clear,
    input  logic             clr_sie,
    input  logic             clr_all,
    output logic             cpu_busy,
    output logic             cpu_valid,
    output logic [LEN_W-1:0] cpu_len,
    output logic             tx_avail,
    output logic [LEN_W-1:0] tx_len,
    input  logic             tx_rd,
    output logic [DW-1:0]    tx_data,
    input  logic             tx_done
);
    import inep_pkg::*;

    typedef struct packed {
        logic [1:0]            full;
        logic [1:0][LEN_W-1:0] len;
        half_t                 cpu;
        half_t                 sie;
        logic                  zlp_pend;
        half_t                 zlp_half;
    } st_t;

    st_t             st_d, st_q;
    logic            rd_clr;
    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    logic [IDX_W-1:0] rd_ptr;
    half_t           ch;

    always_comb begin
        st_d    = st_q;
        rd_clr  = 1'b0;
        wr_en   = 1'b0;
        wr_addr = '0;
        ch      = st_q.cpu;
        if (clr_all) begin
            st_d   = '0;
            rd_clr = 1'b1;
        end else begin
            // serial side: packet sent or discarded
            if ((tx_done || clr_sie) && st_q.full[st_q.sie]) begin
                st_d.full[st_q.sie] = 1'b0;
                st_d.len[st_q.sie]  = '0;
                rd_clr              = 1'b1;
                if (st_q.zlp_pend && st_q.zlp_half == st_q.sie)
                    st_d.zlp_pend = 1'b0;
                st_d.sie = next_half(st_q.sie, dbl_mode);
            end
            ch = st_d.cpu;
            // processor side: clear acts before commit
            if (ctl_wr && ctl_clear) begin
                if (dbl_mode && st_d.full[ch]) begin
                    if (st_d.sie == ch) begin
                        rd_clr   = 1'b1;
                        st_d.sie = ~ch;
                    end
                    st_d.full[ch] = 1'b0;
                end
                if (!st_d.full[ch]) begin
                    st_d.len[ch] = '0;
                    if (st_d.zlp_pend && st_d.zlp_half == ch)
                        st_d.zlp_pend = 1'b0;
                end
            end
            if (ctl_wr && ctl_commit) begin
                if (!st_d.full[ch]) begin
                    st_d.full[ch] = 1'b1;
                    if (ctl_clear) begin
                        st_d.zlp_pend = 1'b1;
                        st_d.zlp_half = ch;
                    end
                    st_d.cpu = next_half(ch, dbl_mode);
                end
            end else if (cpu_wr_en && !ctl_wr && !st_d.full[ch]) begin
                wr_en        = 1'b1;
                wr_addr      = {ch, st_d.len[ch][IDX_W-1:0]};
                st_d.len[ch] = st_d.len[ch] + LEN_W'(1);
                if (st_d.len[ch] == LEN_W'(MAXP)) begin
                    st_d.full[ch] = 1'b1;
                    st_d.cpu      = next_half(ch, dbl_mode);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    inep_rdptr #(.W(IDX_W)) u_rdptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rd_clr),
        .inc   (tx_rd && st_q.full[st_q.sie] && !rd_clr),
        .ptr   (rd_ptr)
    );

    inep_store #(.DW(DW), .DEPTH(2 * (1 << IDX_W))) u_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (cpu_wr_data),
        .raddr ({st_q.sie, rd_ptr}),
        .rdata (tx_data)
    );

    assign cpu_busy  = st_q.full[st_q.cpu];
    assign cpu_len   = st_q.len[st_q.cpu];
    assign cpu_valid = st_q.zlp_pend;
    assign tx_avail  = st_q.full[st_q.sie];
    assign tx_len    = st_q.len[st_q.sie];

endmodule

// File: rtl/inep_chk.sv
module inep_chk #(
    parameter int MAXP    = 64,
    localparam int LEN_W  = $clog2(MAXP + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dbl_mode,
    input logic             cpu_wr_en,
    input logic             ctl_wr,
    input logic             ctl_commit,
    input logic             ctl_clear,
    input logic             clr_sie,
    input logic             clr_all,
    input logic             cpu_busy,
    input logic             cpu_valid,
    input logic [LEN_W-1:0] cpu_len,
    input logic             tx_avail,
    input logic             tx_done
);

    logic quiet;
    assign quiet = !ctl_wr && !clr_all && !clr_sie && !tx_done;

    // R11
    clear_all_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> !tx_avail && !cpu_busy && !cpu_valid && cpu_len == '0);

    // R2
    byte_write_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_en && quiet && !cpu_busy && cpu_len < LEN_W'(MAXP - 1)
        |=> cpu_len == $past(cpu_len) + LEN_W'(1));

    // R8
    full_packet_commits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_en && quiet && !cpu_busy && cpu_len == LEN_W'(MAXP - 1)
        |=> tx_avail);

    // R9
    single_busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dbl_mode && cpu_busy && !tx_done && !clr_sie && !clr_all |=> cpu_busy);

    // R7
    flush_send_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && ctl_commit && ctl_clear && !clr_all && !clr_sie && !tx_done
        && (dbl_mode || !cpu_busy) |=> cpu_valid && tx_avail);

    // R3
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_busy && cpu_wr_en && quiet |=> cpu_busy && $stable(cpu_len));

    // R10
    offer_drops_on_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_avail) |-> $past(tx_done || clr_sie || clr_all || (ctl_wr && ctl_clear)));

endmodule

bind inep_tx_buffer inep_chk #(.MAXP(MAXP)) u_inep_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dbl_mode   (dbl_mode),
    .cpu_wr_en  (cpu_wr_en),
    .ctl_wr     (ctl_wr),
    .ctl_commit (ctl_commit),
    .ctl_clear  (ctl_clear),
    .clr_sie    (clr_sie),
    .clr_all    (clr_all),
    .cpu_busy   (cpu_busy),
    .cpu_valid  (cpu_valid),
    .cpu_len    (cpu_len),
    .tx_avail   (tx_avail),
    .tx_done    (tx_done)
);

// File: tb/test_inep_tx_buffer.sv
`timescale 1ns/1ps
module test_inep_tx_buffer;
    localparam int DW    = 8;
    localparam int MAXP  = 8;
    localparam int LEN_W = $clog2(MAXP + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dbl_mode = 1'b0;
    logic cpu_wr_en = 1'b0;
    logic [DW-1:0] cpu_wr_data = '0;
    logic ctl_wr = 1'b0, ctl_commit = 1'b0, ctl_clear = 1'b0;
    logic clr_sie = 1'b0, clr_all = 1'b0;
    logic tx_rd = 1'b0, tx_done = 1'b0;
    logic cpu_busy, cpu_valid, tx_avail;
    logic [LEN_W-1:0] cpu_len, tx_len;
    logic [DW-1:0] tx_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    inep_tx_buffer #(.DW(DW), .MAXP(MAXP)) i_inep_tx_buffer (
        .clk(clk), .rst_n(rst_n), .dbl_mode(dbl_mode),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
        .ctl_wr(ctl_wr), .ctl_commit(ctl_commit), .ctl_clear(ctl_clear),
        .clr_sie(clr_sie), .clr_all(clr_all),
        .cpu_busy(cpu_busy), .cpu_valid(cpu_valid), .cpu_len(cpu_len),
        .tx_avail(tx_avail), .tx_len(tx_len), .tx_rd(tx_rd),
        .tx_data(tx_data), .tx_done(tx_done)
    );

    function automatic int pat(int n, int i);
        return (n * 16 + i * 3 + 7) & 255;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wbyte(int v);
        cpu_wr_en = 1'b1; cpu_wr_data = DW'(v);
        tick();
        cpu_wr_en = 1'b0;
    endtask

    task automatic ctl(logic c, logic k);
        ctl_wr = 1'b1; ctl_commit = c; ctl_clear = k;
        tick();
        ctl_wr = 1'b0; ctl_commit = 1'b0; ctl_clear = 1'b0;
    endtask

    task automatic fill(int n, int seed);
        for (int i = 0; i < n; i++) wbyte(pat(seed, i));
    endtask

    task automatic drain(int n, int seed, string req);
        for (int i = 0; i < n; i++) begin
            chk(req, tx_data, pat(seed, i));
            tx_rd = 1'b1; tick(); tx_rd = 1'b0;
        end
        tx_done = 1'b1; tick(); tx_done = 1'b0;
    endtask

    task automatic restart(logic m);
        dbl_mode = m; clr_all = 1'b1; tick(); clr_all = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1
        chk("R1 busy", cpu_busy, 0);
        chk("R1 avail", tx_avail, 0);
        chk("R1 valid", cpu_valid, 0);
        chk("R1 len", cpu_len, 0);
        rst_n = 1'b1;
        tick();

        // length sweep in both modes: R2 R4 R5 R8 R9 R10
        for (int m = 0; m < 2; m++) begin
            restart(m[0]);
            for (int n = 0; n <= MAXP; n++) begin
                string tg;
                tg = (n == 0) ? "R5" : (n == MAXP) ? "R8" : "R4";
                fill(n, n + m * 9);
                if (n < MAXP) begin
                    chk("R2 len", cpu_len, n);
                    ctl(1'b1, 1'b0);
                end
                chk(tg, tx_avail, 1);
                chk(tg, tx_len, n);
                chk(m ? "R10 busy" : "R9 busy", cpu_busy, m ? 0 : 1);
                drain(n, n + m * 9, "R2 data");
                chk(tg, tx_avail, 0);
                chk("R9 free", cpu_busy, 0);
            end
        end

        // single mode: R3 R9 R12 R6 R7
        restart(1'b0);
        fill(2, 40);
        ctl(1'b1, 1'b0);
        wbyte(99);
        chk("R3 len", tx_len, 2);
        chk("R9 busy", cpu_busy, 1);
        ctl(1'b0, 1'b1);
        chk("R6 single busy", cpu_busy, 1);
        drain(2, 40, "R3 data");
        fill(3, 41);
        clr_sie = 1'b0;
        ctl(1'b1, 1'b0);
        clr_sie = 1'b1; tick(); clr_sie = 1'b0;
        chk("R9 sie clear busy", cpu_busy, 0);
        chk("R11 sie clear avail", tx_avail, 0);
        fill(4, 42);
        ctl(1'b0, 1'b1);
        chk("R6 len", cpu_len, 0);
        chk("R6 avail", tx_avail, 0);
        chk("R6 valid", cpu_valid, 0);
        fill(2, 43);
        cpu_wr_en = 1'b1; cpu_wr_data = 8'hEE;
        ctl(1'b1, 1'b0);
        cpu_wr_en = 1'b0;
        chk("R12 len", tx_len, 2);
        drain(2, 43, "R6 data");
        fill(3, 44);
        ctl(1'b1, 1'b1);
        chk("R7 avail", tx_avail, 1);
        chk("R7 zero", tx_len, 0);
        chk("R7 valid", cpu_valid, 1);
        tick();
        chk("R7 valid hold", cpu_valid, 1);
        tx_done = 1'b1; tick(); tx_done = 1'b0;
        chk("R7 valid drop", cpu_valid, 0);
        chk("R7 avail drop", tx_avail, 0);

        // double mode ordering: R10 R3
        restart(1'b1);
        fill(3, 50);
        ctl(1'b1, 1'b0);
        chk("R10 one half", cpu_busy, 0);
        fill(2, 51);
        ctl(1'b1, 1'b0);
        chk("R10 both", cpu_busy, 1);
        wbyte(77);
        chk("R3 double", cpu_busy, 1);
        chk("R10 first", tx_len, 3);
        drain(3, 50, "R10 data");
        chk("R10 freed", cpu_busy, 0);
        chk("R10 second", tx_len, 2);
        drain(2, 51, "R10 data");
        chk("R10 empty", tx_avail, 0);

        // double mode clear of a committed half: R6
        fill(3, 52);
        ctl(1'b1, 1'b0);
        fill(2, 53);
        ctl(1'b1, 1'b0);
        ctl(1'b0, 1'b1);
        chk("R6 double busy", cpu_busy, 0);
        chk("R6 double keeps newer", tx_len, 2);
        drain(2, 53, "R6 data");
        chk("R6 double empty", tx_avail, 0);

        // clear everything: R11
        fill(3, 54);
        ctl(1'b1, 1'b0);
        fill(1, 55);
        restart(1'b1);
        chk("R11 avail", tx_avail, 0);
        chk("R11 len", cpu_len, 0);
        chk("R11 busy", cpu_busy, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule